// File: doc/BRIEF.md
# Multi-Source Reset Pulse Generator

This block merges several fault indications into one system reset and stretches that reset by a selectable timeout. Its fault sources are two supply-undervoltage flags, one auxiliary-input undervoltage flag, an active-low manual-reset pin and a one-cycle watchdog-expiry strobe. The supply and auxiliary flags come from external comparators and arrive as synchronous logic levels. A level fault holds reset for as long as it is present. When the last fault clears, a timeout starts. Reset is released only once that timeout has run to its end. A fault that comes back in the meantime restarts the timeout from zero.

There are three reset outputs. The primary output is active low. An active-high copy follows it exactly. A secondary active-low output reacts only to the two supplies and the manual pin. A separate active-low power-fail output follows the power-fail flag with no stretching. The timeout is counted in ticks of a prescaled time base. A 3-bit code picks one of eight tick counts, and each count is a parameter. The manual pin is synchronised and then deglitched, so that short low glitches are ignored.

Top module: `rst_pulse_gen`

## Requirements
- R1: The primary reset (`rst_n_o`) goes low within one clock after any of `sup1_low_i`, `sup2_low_i`, `aux_low_i` or `wd_expire_i` is seen high at a clock edge. It also goes low after the filtered manual input goes low.
- R2: Once no fault is present, the primary reset is released on the clock tick that completes the selected number of time-base ticks. The time base produces one tick every `PRESCALE` clocks.
- R3: If a fault returns before the timeout completes, the tick count restarts from zero. The full selected timeout is then needed after that fault clears.
- R4: While the filtered manual input is low, the reset stays asserted. The timeout begins only after the input returns high.
- R5: `tmo_sel_i` value k (0 to 7) selects entry k of the `TICKS` table. A zero entry is treated as one tick. The defaults give 1.65, 13.2, 26.25, 52.5, 210, 420, 840 and 1680 ms for a 100 MHz clock and a 50 µs tick.
- R6: `mr_n_i` passes through a two-flop synchroniser. The filtered value changes only after the synchronised input has differed from it for `MR_FILT` consecutive clocks, so a shorter low pulse has no effect on any reset output.
- R7: The secondary reset `rst2_n_o` uses the same timeout but is driven only by the supply flags and the manual input. `aux_low_i` and `wd_expire_i` do not affect it.
- R8: `rst_o` is always the complement of `rst_n_o`.
- R9: `pfo_n_o` equals the inverse of `pf_low_i` at every moment. It has no timeout and no clocking.
- R10: After the block's own reset (`rst_ni` low), both resets are asserted. A full timeout then runs before either is released.
- R11: A watchdog strobe lasting one cycle starts a full timeout on the primary reset, and the reset is held for that whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block itself |
| sup1_low_i | input | 1 | Supply 1 below threshold (high = fault) |
| sup2_low_i | input | 1 | Supply 2 below threshold (high = fault) |
| aux_low_i | input | 1 | Auxiliary input below threshold (high = fault) |
| mr_n_i | input | 1 | Manual reset request, active low, asynchronous |
| wd_expire_i | input | 1 | Watchdog expiry strobe, one cycle |
| tmo_sel_i | input | 3 | Timeout select code |
| pf_low_i | input | 1 | Power-fail flag (high = fault) |
| rst_n_o | output | 1 | Primary reset, active low |
| rst_o | output | 1 | Primary reset, active high |
| rst2_n_o | output | 1 | Secondary reset, active low |
| pfo_n_o | output | 1 | Power-fail output, active low |

## Verification
The bench builds the block with `PRESCALE` = 4, `MR_FILT` = 3 and a tick table of 1, 2, 3, 5, 6, 8, 10 and 12. With these values every timeout code finishes within about fifty clocks, so all eight codes can be measured one after another. The small values also bring restart-during-timeout and manual glitches just shorter and just longer than the filter window within a few cycles. A tick can fall anywhere relative to when a fault clears, and the short prescaler means both the earliest and the latest placement occur during the run.

// File: rtl/rst_pulse_gen_pkg.sv
package rst_pulse_gen_pkg;
  localparam int unsigned NSEL  = 8;
  localparam int unsigned SEL_W = $clog2(NSEL);

  // A zero table entry would release at once; clamp it to one tick.
  function automatic int unsigned tmo_limit(input int unsigned raw);
    return (raw == 0) ? 1 : raw;
  endfunction

  // Tick count reached after one more tick.
  function automatic logic tmo_done(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction
endpackage

// File: rtl/rg_prescaler.sv
module rg_prescaler #(
  parameter int unsigned PRESCALE = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PC_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PRESCALE - 1);

  logic [PC_W-1:0] pc_q;
  logic            wrap;

  assign wrap   = (pc_q == PC_LAST);
  assign tick_o = wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pc_q <= '0;
    else if (wrap) pc_q <= '0;
    else           pc_q <= pc_q + 1'b1;
  end

  generate
    if (PRESCALE > 1) begin : g_space
      AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o); // R2
    end
  endgenerate
endmodule

// File: rtl/rg_deglitch.sv
module rg_deglitch #(
  parameter int unsigned MR_FILT = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_n_i,
  output logic filt_n_o
);
  localparam int unsigned FC_W = $clog2(MR_FILT + 1);
  localparam logic [FC_W-1:0] FC_LAST = FC_W'(MR_FILT - 1);

  logic            s1_q, s2_q, filt_q;
  logic [FC_W-1:0] fc_q;
  logic            differs, accept;

  assign differs  = (s2_q != filt_q);
  assign accept   = differs && (fc_q == FC_LAST);
  assign filt_n_o = filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      filt_q <= 1'b1;
      fc_q   <= '0;
    end else begin
      s1_q <= raw_n_i;
      s2_q <= s1_q;
      if (!differs) begin
        fc_q <= '0;
      end else if (accept) begin
        filt_q <= s2_q;
        fc_q   <= '0;
      end else begin
        fc_q <= fc_q + 1'b1;
      end
    end
  end

  AST_FILT_NEEDS_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_q != $past(filt_q)) |-> ($past(s2_q) == filt_q)); // R6
endmodule

// File: rtl/rg_stretch.sv
module rg_stretch #(
  parameter int unsigned TICK_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_i,
  input  logic              tick_i,
  input  logic [TICK_W-1:0] limit_i,
  output logic              active_o
);
  import rst_pulse_gen_pkg::*;

  logic [TICK_W-1:0] cnt_q;
  logic              act_q;
  logic              finish;

  assign finish   = act_q && tick_i && tmo_done(cnt_q, limit_i);
  assign active_o = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (fault_i) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (finish) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (act_q && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_FAULT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> act_q); // R3
  AST_RELEASE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act_q) |-> ($past(tick_i) && !$past(fault_i))); // R2
  AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q |-> (cnt_q == '0)); // R2
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
  parameter int unsigned PRESCALE = 5000,
  parameter int unsigned MR_FILT  = 20,
  parameter int unsigned TICK_W   = 16,
  parameter int unsigned TICKS [8] = '{33, 264, 525, 1050, 4200, 8400, 16800, 33600}
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sup1_low_i,
  input  logic       sup2_low_i,
  input  logic       aux_low_i,
  input  logic       mr_n_i,
  input  logic       wd_expire_i,
  input  logic [2:0] tmo_sel_i,
  input  logic       pf_low_i,
  output logic       rst_n_o,
  output logic       rst_o,
  output logic       rst2_n_o,
  output logic       pfo_n_o
);
  import rst_pulse_gen_pkg::*;

  localparam int unsigned NCH = 2; // 0: primary, 1: secondary

  logic              tick;
  logic              mr_filt_n;
  logic [TICK_W-1:0] lim_tab [NSEL];
  logic [TICK_W-1:0] limit;
  logic [NCH-1:0]    ch_fault;
  logic [NCH-1:0]    ch_active;
  logic              supply_fault;

  genvar g;
  generate
    for (g = 0; g < NSEL; g++) begin : g_lim
      assign lim_tab[g] = TICK_W'(tmo_limit(TICKS[g]));
    end
  endgenerate

  assign limit        = lim_tab[tmo_sel_i];
  assign supply_fault = sup1_low_i | sup2_low_i | !mr_filt_n;
  assign ch_fault[0]  = supply_fault | aux_low_i | wd_expire_i;
  assign ch_fault[1]  = supply_fault;

  rg_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  rg_deglitch #(.MR_FILT(MR_FILT)) u_mr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_n_i (mr_n_i),
    .filt_n_o(mr_filt_n)
  );

  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      rg_stretch #(.TICK_W(TICK_W)) u_str (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .fault_i (ch_fault[g]),
        .tick_i  (tick),
        .limit_i (limit),
        .active_o(ch_active[g])
      );
    end
  endgenerate

  assign rst_n_o  = !ch_active[0];
  assign rst_o    = ch_active[0];
  assign rst2_n_o = !ch_active[1];
  assign pfo_n_o  = !pf_low_i;

  AST_LEVEL_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sup1_low_i || sup2_low_i || aux_low_i) |=> !rst_n_o); // R1
  AST_WD_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_expire_i |=> !rst_n_o); // R11
  AST_MR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mr_filt_n |=> (!rst_n_o && !rst2_n_o)); // R4
  AST_SECONDARY_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst2_n_o |-> !rst_n_o); // R7
  always_comb begin
    AST_HIGH_COPY: assert (rst_o == !rst_n_o); // R8
  end
endmodule

// File: tb/rst_pulse_gen_tb_top.sv
module rst_pulse_gen_tb_top;
  localparam int P = 4;
  localparam int F = 3;
  localparam int unsigned TT [8] = '{1, 2, 3, 5, 6, 8, 10, 12};

  logic clk = 0;
  logic rst_ni = 0;
  logic sup1 = 0, sup2 = 0, aux = 0, mr_n = 1, wd = 0, pf = 0;
  logic [2:0] sel = 0;
  logic rst_n_o, rst_o, rst2_n_o, pfo_n_o;

  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  rst_pulse_gen #(.PRESCALE(P), .MR_FILT(F), .TICK_W(8), .TICKS(TT)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sup1_low_i(sup1), .sup2_low_i(sup2),
    .aux_low_i(aux), .mr_n_i(mr_n), .wd_expire_i(wd), .tmo_sel_i(sel),
    .pf_low_i(pf), .rst_n_o(rst_n_o), .rst_o(rst_o), .rst2_n_o(rst2_n_o),
    .pfo_n_o(pfo_n_o));

  // Behavioural reference: time base phase, a delay queue for the
  // synchroniser, a run-length count for the filter, tick totals per output.
  int  m_phase;
  bit  m_q[$];
  bit  m_mr;
  int  m_run;
  int  m_t1, m_t2;
  bit  m_a1, m_a2;

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_phase = 0; m_q = '{1'b1, 1'b1}; m_mr = 1; m_run = 0;
      m_t1 = 0; m_t2 = 0; m_a1 = 1; m_a2 = 1;
    end else begin
      bit tk, f1, f2, seen;
      int lim;
      tk  = (m_phase == P - 1);
      lim = (TT[sel] == 0) ? 1 : int'(TT[sel]);
      f2  = sup1 || sup2 || !m_mr;
      f1  = f2 || aux || wd;
      if (f1) begin m_a1 = 1; m_t1 = 0; end
      else if (m_a1 && tk) begin
        m_t1++; if (m_t1 >= lim) begin m_a1 = 0; m_t1 = 0; end
      end
      if (f2) begin m_a2 = 1; m_t2 = 0; end
      else if (m_a2 && tk) begin
        m_t2++; if (m_t2 >= lim) begin m_a2 = 0; m_t2 = 0; end
      end
      seen = m_q.pop_front();
      if (seen == m_mr) m_run = 0;
      else begin
        m_run++; if (m_run >= F) begin m_mr = seen; m_run = 0; end
      end
      m_q.push_back(mr_n);
      m_phase = (m_phase + 1) % P;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  // Per-cycle comparison against the reference, away from the clock edge.
  always @(negedge clk) begin
    cyc++;
    if (rst_ni && cyc > 2) begin
      chk("R2 primary vs model", rst_n_o, !m_a1);
      chk("R8 high copy", rst_o, !rst_n_o);
      chk("R7 secondary vs model", rst2_n_o, !m_a2);
      chk("R9 power-fail", pfo_n_o, !pf);
    end
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_rel(output int n);
    n = 0;
    while (n < 1000) begin
      @(negedge clk); n++;
      if (rst_n_o) break;
    end
    #1;
  endtask

  initial begin
    int n;
    step(3);
    chk("R10 reset state primary", rst_n_o, 0);
    chk("R10 reset state secondary", rst2_n_o, 0);
    rst_ni = 1;
    wait_rel(n);
    chk_rng("R10 first release", n, (int'(TT[0]) - 1) * P, int'(TT[0]) * P + 1);

    // R5: each code gives its own tick count
    for (int k = 0; k < 8; k++) begin
      sel = 3'(k);
      sup1 = 1; step(3); sup1 = 0;
      wait_rel(n);
      chk_rng($sformatf("R5 sel %0d length", k), n, (int'(TT[k]) - 1) * P, int'(TT[k]) * P + 1);
      step(2);
    end

    // R1: each level source asserts within one clock
    sel = 3'd1;
    sup2 = 1; step(1); chk("R1 sup2", rst_n_o, 0); sup2 = 0; wait_rel(n);
    aux = 1;  step(1); chk("R1 aux", rst_n_o, 0);
    chk("R7 aux ignored by secondary", rst2_n_o, 1); aux = 0; wait_rel(n);

    // R11 and R7: one-cycle watchdog strobe
    sel = 3'd4;
    wd = 1; step(1); wd = 0;
    chk("R11 strobe asserts", rst_n_o, 0);
    chk("R7 wd ignored by secondary", rst2_n_o, 1);
    step(16);
    chk("R11 held after strobe", rst_n_o, 0);
    wait_rel(n);
    chk_rng("R11 full timeout", n, (int'(TT[4]) - 1) * P - 17, int'(TT[4]) * P + 1);

    // R3: fault returns mid-timeout
    sup1 = 1; step(2); sup1 = 0; step(12);
    chk("R3 still asserted mid-timeout", rst_n_o, 0);
    sup1 = 1; step(1); sup1 = 0;
    wait_rel(n);
    chk_rng("R3 restarted length", n, (int'(TT[4]) - 1) * P, int'(TT[4]) * P + 1);

    // R6: glitch shorter than the filter is ignored
    sel = 3'd0;
    mr_n = 0; step(F - 1); mr_n = 1; step(10);
    chk("R6 short glitch primary", rst_n_o, 1);
    chk("R6 short glitch secondary", rst2_n_o, 1);
    mr_n = 0; step(F + 4);
    chk("R6 long pulse accepted", rst_n_o, 0);

    // R4: held low keeps reset; timeout starts after release
    step(40);
    chk("R4 held primary", rst_n_o, 0);
    chk("R4 held secondary", rst2_n_o, 0);
    sel = 3'd2;
    mr_n = 1;
    step(2 + F);
    chk("R4 still in timeout", rst_n_o, 0);
    wait_rel(n);
    chk_rng("R4 timeout after high", n, (int'(TT[2]) - 1) * P - 5, int'(TT[2]) * P + 1);

    // R9: power-fail passes straight through
    pf = 1; #2; chk("R9 pf low", pfo_n_o, 0);
    chk("R9 no reset effect", rst_n_o, 1);
    pf = 0; #2; chk("R9 pf release", pfo_n_o, 1);
    step(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule